// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address stream of one SDRAM-style read or write burst. A mode write loads a packed control word that sets the burst length, the ordering of beats inside a burst, the write burst mode and a CAS latency field. A start pulse carries the first column and a read/write flag. From the next cycle on, the block emits one qualified column per clock.

Fixed bursts of 2, 4 or 8 stay inside an aligned block of that many columns. A full-page burst walks the whole page and wraps, and it runs until a terminate pulse or a new start stops it. A control option turns every write into a single-beat access while reads keep the programmed length. The CAS latency field is only held and presented to the surrounding controller.

Top module: `sdram_burst_seq`

## Requirements
- R1: Synchronous active-high reset leaves no burst active (`col_valid`=0, `col_last`=0), sets `cas_lat` to 3'b010 and restores length 1, sequential order and burst writes.
- R2: `mode_word[2:0]` selects the length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives full page, and every other code gives 1.
- R3: With `mode_word[3]`=0 (sequential), beat n carries low block bits equal to (start low bits + n) modulo the length.
- R4: With `mode_word[3]`=1 (interleaved), beat n carries low block bits equal to start low bits XOR n.
- R5: In a fixed burst of length L, all column bits above the low log2(L) bits keep the start value on every beat.
- R6: A start sampled at a clock edge shows `start_col` with `col_valid`=1 right after that edge, and each later edge shows the next beat.
- R7: `col_last` is high together with the final beat of a fixed burst only; `col_valid` falls on the following edge unless a start arrives.
- R8: A full-page burst adds 1 per beat, wraps from the all-ones column to 0, never raises `col_last`, and stops (`col_valid`=0) on the edge that samples `term`; `term` also ends a fixed burst early.
- R9: With `mode_word[9]`=1, a write start gives exactly one beat with `col_last`=1; read starts still use the programmed length.
- R10: `mode_word[6:4]` is latched on a mode write and driven on `cas_lat`.
- R11: A start during a burst abandons it and the new sequence appears after that edge; start wins over `term` in the same cycle.
- R12: A mode write during a burst leaves that burst's length, order and addresses unchanged; a start uses the mode held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Load `mode_word` into the mode register |
| mode_word | input | MODE_W | Packed mode word |
| start | input | 1 | Begin a burst at `start_col` |
| is_write | input | 1 | The starting burst is a write |
| start_col | input | COL_W | First column of the burst |
| term | input | 1 | Stop the active burst |
| col | output | COL_W | Current column address |
| col_valid | output | 1 | `col` holds a beat |
| col_last | output | 1 | Final beat of a fixed burst |
| cas_lat | output | 3 | Latched CAS latency field |

## Verification
The first beat is due one edge after the start pulse, each later beat one edge after the previous, and the drop of `col_valid` one edge after the final beat or the terminate pulse. A mode write shows on `cas_lat` one edge after it. The bench drives every input on the falling edge and reads every output on the falling edge that follows the relevant rising edge, so each sample falls half a period after the register update it expects.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int COL_W  = 10,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic              is_write,
  input  logic [COL_W-1:0]  start_col,
  input  logic              term,
  output logic [COL_W-1:0]  col,
  output logic              col_valid,
  output logic              col_last,
  output logic [2:0]        cas_lat
);

  localparam int LOW_W = 3;

  logic [2:0]       m_len;
  logic             m_il;
  logic             m_wsingle;

  logic [1:0]       b_k;
  logic             b_full;
  logic             b_il;
  logic [LOW_W-1:0] b_start;
  logic [LOW_W-1:0] beat;

  logic [1:0]       s_k;
  logic             s_full;

  always_comb begin
    s_k    = 2'd0;
    s_full = 1'b0;
    if (!(is_write && m_wsingle)) begin
      case (m_len)
        3'b001:  s_k = 2'd1;
        3'b010:  s_k = 2'd2;
        3'b011:  s_k = 2'd3;
        3'b111:  s_full = 1'b1;
        default: s_k = 2'd0;
      endcase
    end
  end

  logic [3:0]       mask4;
  logic [LOW_W-1:0] b_mask;
  logic [LOW_W-1:0] nxt_beat;
  logic [LOW_W-1:0] nxt_low;
  logic [COL_W-1:0] nxt_fixed;

  assign mask4     = (4'd1 << b_k) - 4'd1;
  assign b_mask    = mask4[LOW_W-1:0];
  assign nxt_beat  = beat + 1'b1;
  assign nxt_low   = b_il ? (b_start ^ nxt_beat) : (b_start + nxt_beat);
  assign nxt_fixed = {col[COL_W-1:LOW_W], (col[LOW_W-1:0] & ~b_mask) | (nxt_low & b_mask)};
  assign col_last  = col_valid && !b_full && (beat == b_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_len     <= 3'b000;
      m_il      <= 1'b0;
      m_wsingle <= 1'b0;
      cas_lat   <= 3'b010;
      col_valid <= 1'b0;
      col       <= '0;
      beat      <= '0;
      b_k       <= 2'd0;
      b_full    <= 1'b0;
      b_il      <= 1'b0;
      b_start   <= '0;
    end else begin
      if (mode_wr) begin
        m_len     <= mode_word[2:0];
        m_il      <= mode_word[3];
        cas_lat   <= mode_word[6:4];
        m_wsingle <= mode_word[9];
      end
      if (start) begin
        col       <= start_col;
        col_valid <= 1'b1;
        beat      <= '0;
        b_k       <= s_k;
        b_full    <= s_full;
        b_il      <= m_il;
        b_start   <= start_col[LOW_W-1:0];
      end else if (col_valid) begin
        if (term || col_last) begin
          col_valid <= 1'b0;
        end else begin
          beat <= nxt_beat;
          col  <= b_full ? col + 1'b1 : nxt_fixed;
        end
      end
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!col_valid && cas_lat == 3'b010));

  p_first_beat_r6: assert property (@(posedge clk) disable iff (rst)
    start |=> (col_valid && col == $past(start_col)));

  p_last_qualified_r7: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  p_end_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    (col_last && !start) |=> !col_valid);

  p_block_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !b_full && !col_last && !start && !term)
      |=> (col_valid && col[COL_W-1:LOW_W] == $past(col[COL_W-1:LOW_W])));

  p_page_step_r8: assert property (@(posedge clk) disable iff (rst)
    (col_valid && b_full && !start && !term)
      |=> (col_valid && !col_last && col == $past(col) + 1'b1));

  p_term_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (col_valid && term && !start) |=> !col_valid);

  p_single_write_r9: assert property (@(posedge clk) disable iff (rst)
    (start && is_write && m_wsingle) |=> col_last);

  p_cas_load_r10: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (cas_lat == $past(mode_word[6:4])));

endmodule

// File: tb/sdram_burst_seq_tb.sv
`timescale 1ns/1ps
module sdram_burst_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr = 1'b0;
  logic [11:0] mode_word = '0;
  logic        start = 1'b0;
  logic        is_write = 1'b0;
  logic [9:0]  start_col = '0;
  logic        term = 1'b0;
  logic [9:0]  col;
  logic        col_valid;
  logic        col_last;
  logic [2:0]  cas_lat;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_burst_seq #(.COL_W(10), .MODE_W(12)) u_dut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_word(mode_word),
    .start(start), .is_write(is_write), .start_col(start_col), .term(term),
    .col(col), .col_valid(col_valid), .col_last(col_last), .cas_lat(cas_lat)
  );

  typedef struct packed {
    logic [11:0] mode;
    logic [9:0]  scol;
    logic        wr;
    logic [3:0]  n;
    logic [79:0] exp;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{12'h020, 10'h155, 1'b0, 4'd1, {70'h0, 10'h155}},                           // R2 len 1
    '{12'h021, 10'h0F3, 1'b0, 4'd2, {60'h0, 10'h0F2, 10'h0F3}},                  // R3 seq 2
    '{12'h022, 10'h0F6, 1'b0, 4'd4, {40'h0, 10'h0F5, 10'h0F4, 10'h0F7, 10'h0F6}}, // R3 seq 4
    '{12'h023, 10'h10D, 1'b0, 4'd8, {10'h10C, 10'h10B, 10'h10A, 10'h109,
                                      10'h108, 10'h10F, 10'h10E, 10'h10D}},        // R5 seq 8
    '{12'h02B, 10'h10D, 1'b0, 4'd8, {10'h10A, 10'h10B, 10'h108, 10'h109,
                                      10'h10E, 10'h10F, 10'h10C, 10'h10D}},        // R4 il 8
    '{12'h02A, 10'h3F1, 1'b0, 4'd4, {40'h0, 10'h3F2, 10'h3F3, 10'h3F0, 10'h3F1}}, // R4 il 4
    '{12'h029, 10'h000, 1'b0, 4'd2, {60'h0, 10'h001, 10'h000}},                  // R4 il 2
    '{12'h224, 10'h123, 1'b0, 4'd1, {70'h0, 10'h123}},                           // R2 reserved
    '{12'h223, 10'h0AB, 1'b1, 4'd1, {70'h0, 10'h0AB}},                           // R9 single write
    '{12'h223, 10'h0AB, 1'b0, 4'd8, {10'h0AA, 10'h0A9, 10'h0A8, 10'h0AF,
                                      10'h0AE, 10'h0AD, 10'h0AC, 10'h0AB}},        // R9 read full len
    '{12'h023, 10'h3FF, 1'b1, 4'd8, {10'h3FE, 10'h3FD, 10'h3FC, 10'h3FB,
                                      10'h3FA, 10'h3F9, 10'h3F8, 10'h3FF}},        // R9 burst write
    '{12'h035, 10'h200, 1'b0, 4'd1, {70'h0, 10'h200}}                            // R10 CL field
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [11:0] w);
    mode_wr = 1'b1;
    mode_word = w;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic kick(input logic [9:0] c, input logic wr);
    start = 1'b1;
    start_col = c;
    is_write = wr;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic beat(input string req, input logic [9:0] c, input logic last);
    check(req, {21'h0, col_valid, col_last, col}, {21'h0, 1'b1, last, c});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 reset valid/last", {col_valid, col_last}, 2'b00);
    check("R1 reset cas_lat", cas_lat, 3'b010);
    kick(10'h047, 1'b0);
    beat("R1 default length 1", 10'h047, 1'b1);
    @(negedge clk);
    check("R1 default ends", col_valid, 1'b0);

    for (int i = 0; i < 12; i++) begin
      set_mode(VEC[i].mode);
      check("R10 cas_lat", cas_lat, VEC[i].mode[6:4]);
      kick(VEC[i].scol, VEC[i].wr);
      for (int j = 0; j < int'(VEC[i].n); j++) begin
        beat("R2/R3/R4/R5/R9 vector beat", VEC[i].exp[j*10 +: 10], j == int'(VEC[i].n) - 1);
        @(negedge clk);
      end
      check("R7 valid drops after last", col_valid, 1'b0);
    end

    // R11 abort by new start
    set_mode(12'h023);
    kick(10'h040, 1'b0);
    beat("R6 first beat", 10'h040, 1'b0);
    @(negedge clk);
    beat("R6 second beat", 10'h041, 1'b0);
    kick(10'h085, 1'b0);
    beat("R11 abort restart", 10'h085, 1'b0);
    @(negedge clk);
    beat("R11 new sequence", 10'h086, 1'b0);

    // R8 full page wrap and terminate
    set_mode(12'h027);
    kick(10'h3FD, 1'b0);
    beat("R8 page", 10'h3FD, 1'b0);
    @(negedge clk);
    beat("R8 page", 10'h3FE, 1'b0);
    @(negedge clk);
    beat("R8 page", 10'h3FF, 1'b0);
    @(negedge clk);
    beat("R8 page wrap", 10'h000, 1'b0);
    @(negedge clk);
    beat("R8 page after wrap", 10'h001, 1'b0);
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    check("R8 term stops page", col_valid, 1'b0);

    // R11 start beats term
    term = 1'b1;
    kick(10'h010, 1'b0);
    term = 1'b0;
    beat("R11 start over term", 10'h010, 1'b0);
    @(negedge clk);
    beat("R11 continues", 10'h011, 1'b0);

    // R12 mode write mid-burst
    set_mode(12'h022);
    kick(10'h011, 1'b0);
    beat("R12 beat0", 10'h011, 1'b0);
    set_mode(12'h020);
    beat("R12 beat1", 10'h012, 1'b0);
    @(negedge clk);
    beat("R12 beat2", 10'h013, 1'b0);
    @(negedge clk);
    beat("R12 beat3 last", 10'h010, 1'b1);
    @(negedge clk);
    check("R12 ends at old length", col_valid, 1'b0);

    // R8 term cuts a fixed burst
    set_mode(12'h023);
    kick(10'h100, 1'b0);
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    check("R8 term fixed burst", col_valid, 1'b0);

    // R1 reset mid-burst
    kick(10'h100, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-burst", {col_valid, cas_lat}, {1'b0, 3'b010});

    finish_run();
  end

endmodule